// File: doc/BRIEF.md
# Immediate-Operand Execution Unit

This unit carries out the immediate-operand instructions of a small 8-bit accumulator machine. Each cycle it may accept one 16-bit instruction word, qualified by a valid strobe. It holds the accumulator, a 4-bit bank register, three 12-bit memory pointers and a 16-bit product register. It also holds a five-bit status register.

The upper byte of a word selects the operation and the lower byte is the 8-bit literal. The unit covers add, reverse subtract (literal minus accumulator), AND, OR, XOR, accumulator load, 8x8 unsigned multiply and bank load. It also covers a two-word pointer load. The first word of the pointer load carries the pointer index and the top four literal bits. The second word carries the low eight bits. When a second-word pattern arrives without a first word pending, it does nothing.

Instruction fetch, sequencing and register-file access are handled elsewhere. Any word outside the supported set is flagged on a one-cycle output and leaves all state as it was. All effects appear on the outputs in the cycle after the word is accepted.

Top module: `lit_exec_unit`

## Requirements
- R1: After reset the accumulator, bank, all pointers, product, status (`flags_o` bit 0 C, bit 1 DC, bit 2 Z, bit 3 OV, bit 4 N) and `unsupported_o` are zero.
- R2: Opcode byte 0x0F adds the literal to the accumulator. C is the carry out of bit 7, DC the carry out of bit 3 and OV the signed overflow. Z is set for a zero result and N equals result bit 7.
- R3: Opcode byte 0x08 writes literal minus accumulator. C=1 means no borrow and DC=1 means no borrow out of bit 3. OV is the signed overflow, and Z and N follow the result.
- R4: Opcode bytes 0x0B (AND), 0x09 (OR) and 0x0A (XOR) write the result to the accumulator and change only Z and N.
- R5: Opcode byte 0x0E loads the literal into the accumulator and leaves all flags unchanged.
- R6: Opcode byte 0x0D puts the unsigned product of literal and accumulator into the product register (`prod_o[15:8]` high byte). Accumulator and flags stay unchanged.
- R7: Word pattern 0000_0001_0000_kkkk loads only the bank register with kkkk.
- R8: First word 1110_1110_00pp_hhhh with pp in 0..2, followed by a second word 1111_xxxx_llll_llll, loads pointer pp with {hhhh, llll_llll}. Pointer pp appears at `ptr_o[12*pp +: 12]`. Cycles with the valid strobe low may separate the two words.
- R9: A word with top nibble 1111 that arrives with no first word pending changes nothing and does not raise `unsupported_o`.
- R10: Any valid word other than a second word discards a pending first word. That word executes normally, and a later second word then behaves as in R9.
- R11: An unsupported word (any other encoding, including a first word with pp=3) raises `unsupported_o` for exactly the following cycle and changes no state.
- R12: With the valid strobe low, no state changes whatever the instruction input holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word qualifier |
| instr_word | input | 16 | Instruction word |
| wreg_o | output | 8 | Accumulator |
| bank_o | output | 4 | Bank register |
| ptr_o | output | 36 | Three 12-bit pointers, pointer n at bits 12n+11..12n |
| prod_o | output | 16 | Multiply product, high byte on top |
| flags_o | output | 5 | Status {N, OV, Z, DC, C} |
| unsupported_o | output | 1 | Pulse after an unsupported word |

## Verification
The bench targets the reverse subtract with the borrow-style carry. An operand-swapped or borrow-inverted design would show a wrong accumulator or an inverted C and DC. It drives a positive-minus-negative case that must set OV, which catches an overflow test taken on the wrong operand. It checks that logic operations keep C, DC and OV, and that a multiply leaves flags and accumulator alone, which catches a design that clears or rewrites them. For the pointer load it covers a lone second word, a first word cut off by another instruction, idle cycles between the two words, and the illegal fourth pointer index. A design with sloppy pending-state handling would load a pointer with stale bits or write out of range.

// File: rtl/lit_pkg.sv
package lit_pkg;
    localparam int DATA_W  = 8;
    localparam int WORD_W  = 16;
    localparam int BANK_W  = 4;
    localparam int PTR_W   = 12;
    localparam int NUM_PTR = 3;
    localparam int PROD_W  = 2 * DATA_W;
    localparam int FLAG_W  = 5;
    localparam int SEL_W   = $clog2(NUM_PTR + 1);
    localparam int HI_W    = PTR_W - DATA_W;

    localparam int FL_C  = 0;
    localparam int FL_DC = 1;
    localparam int FL_Z  = 2;
    localparam int FL_OV = 3;
    localparam int FL_N  = 4;

    localparam logic [7:0] OPC_ADD = 8'h0F;
    localparam logic [7:0] OPC_SUB = 8'h08;
    localparam logic [7:0] OPC_AND = 8'h0B;
    localparam logic [7:0] OPC_IOR = 8'h09;
    localparam logic [7:0] OPC_XOR = 8'h0A;
    localparam logic [7:0] OPC_MOV = 8'h0E;
    localparam logic [7:0] OPC_MUL = 8'h0D;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_MOV,
        OP_MUL, OP_BANK, OP_PTR_HI, OP_PTR_LO, OP_BAD
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0]               wreg;
        logic [BANK_W-1:0]               bank;
        logic [NUM_PTR-1:0][PTR_W-1:0]   ptr;
        logic [PROD_W-1:0]               prod;
        logic [FLAG_W-1:0]               flags;
        logic                            pend;
        logic [SEL_W-1:0]                pend_sel;
        logic [HI_W-1:0]                 pend_hi;
        logic                            unsup;
    } state_t;
endpackage

// File: rtl/lit_decode.sv
module lit_decode
    import lit_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output op_e               op_o,
    output logic [DATA_W-1:0] lit_o,
    output logic [SEL_W-1:0]  sel_o
);
    logic [7:0] opc;

    always_comb begin
        opc   = word_i[15:8];
        lit_o = word_i[7:0];
        sel_o = word_i[5:4];
        if (word_i[15:12] == 4'hF) begin
            op_o = OP_PTR_LO;
        end else if (word_i[15:6] == 10'b1110_1110_00) begin
            op_o = (32'(word_i[5:4]) < NUM_PTR) ? OP_PTR_HI : OP_BAD;
        end else if (word_i[15:4] == 12'h010) begin
            op_o = OP_BANK;
        end else begin
            case (opc)
                OPC_ADD: op_o = OP_ADD;
                OPC_SUB: op_o = OP_SUB;
                OPC_AND: op_o = OP_AND;
                OPC_IOR: op_o = OP_IOR;
                OPC_XOR: op_o = OP_XOR;
                OPC_MOV: op_o = OP_MOV;
                OPC_MUL: op_o = OP_MUL;
                default: op_o = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/lit_alu.sv
module lit_alu
    import lit_pkg::*;
(
    input  op_e               op_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic [DATA_W-1:0] k_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [PROD_W-1:0] prod_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] sum_full;
    logic [4:0]      sum_half;
    logic [DATA_W:0] dif_full;
    logic [4:0]      dif_half;

    always_comb begin
        sum_full = {1'b0, w_i} + {1'b0, k_i};
        sum_half = {1'b0, w_i[3:0]} + {1'b0, k_i[3:0]};
        dif_full = {1'b0, k_i} + {1'b0, ~w_i} + {{DATA_W{1'b0}}, 1'b1};
        dif_half = {1'b0, k_i[3:0]} + {1'b0, ~w_i[3:0]} + 5'd1;
        prod_o   = {{DATA_W{1'b0}}, w_i} * {{DATA_W{1'b0}}, k_i};
        res_o    = w_i;
        flags_o  = flags_i;
        case (op_i)
            OP_ADD: begin
                res_o         = sum_full[DATA_W-1:0];
                flags_o[FL_C]  = sum_full[DATA_W];
                flags_o[FL_DC] = sum_half[4];
                flags_o[FL_OV] = (w_i[MSB] == k_i[MSB]) && (res_o[MSB] != w_i[MSB]);
            end
            OP_SUB: begin
                res_o         = dif_full[DATA_W-1:0];
                flags_o[FL_C]  = dif_full[DATA_W];
                flags_o[FL_DC] = dif_half[4];
                flags_o[FL_OV] = (w_i[MSB] != k_i[MSB]) && (res_o[MSB] != k_i[MSB]);
            end
            OP_AND:  res_o = w_i & k_i;
            OP_IOR:  res_o = w_i | k_i;
            OP_XOR:  res_o = w_i ^ k_i;
            OP_MOV:  res_o = k_i;
            default: res_o = w_i;
        endcase
        if (op_i inside {OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR}) begin
            flags_o[FL_Z] = (res_o == '0);
            flags_o[FL_N] = res_o[MSB];
        end
    end
endmodule

// File: rtl/lit_exec_unit.sv
module lit_exec_unit
    import lit_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      instr_valid,
    input  logic [WORD_W-1:0]         instr_word,
    output logic [DATA_W-1:0]         wreg_o,
    output logic [BANK_W-1:0]         bank_o,
    output logic [NUM_PTR*PTR_W-1:0]  ptr_o,
    output logic [PROD_W-1:0]         prod_o,
    output logic [FLAG_W-1:0]         flags_o,
    output logic                      unsupported_o
);
    state_t            st_q, st_d;
    op_e               dec_op;
    logic [DATA_W-1:0] dec_lit;
    logic [SEL_W-1:0]  dec_sel;
    logic [DATA_W-1:0] alu_res;
    logic [FLAG_W-1:0] alu_flags;
    logic [PROD_W-1:0] alu_prod;

    lit_decode u_dec (
        .word_i (instr_word),
        .op_o   (dec_op),
        .lit_o  (dec_lit),
        .sel_o  (dec_sel)
    );

    lit_alu u_alu (
        .op_i    (dec_op),
        .w_i     (st_q.wreg),
        .k_i     (dec_lit),
        .flags_i (st_q.flags),
        .res_o   (alu_res),
        .flags_o (alu_flags),
        .prod_o  (alu_prod)
    );

    always_comb begin
        st_d       = st_q;
        st_d.unsup = 1'b0;
        if (instr_valid) begin
            st_d.pend = 1'b0;
            case (dec_op)
                OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_MOV: begin
                    st_d.wreg  = alu_res;
                    st_d.flags = alu_flags;
                end
                OP_MUL:  st_d.prod = alu_prod;
                OP_BANK: st_d.bank = dec_lit[BANK_W-1:0];
                OP_PTR_HI: begin
                    st_d.pend     = 1'b1;
                    st_d.pend_sel = dec_sel;
                    st_d.pend_hi  = dec_lit[HI_W-1:0];
                end
                OP_PTR_LO: begin
                    for (int i = 0; i < NUM_PTR; i++) begin
                        if (st_q.pend && (32'(st_q.pend_sel) == i))
                            st_d.ptr[i] = {st_q.pend_hi, dec_lit};
                    end
                end
                default: st_d.unsup = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        assign ptr_o[g*PTR_W +: PTR_W] = st_q.ptr[g];
    end

    assign wreg_o        = st_q.wreg;
    assign bank_o        = st_q.bank;
    assign prod_o        = st_q.prod;
    assign flags_o       = st_q.flags;
    assign unsupported_o = st_q.unsup;

    a_r6_mul_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dec_op == OP_MUL) |=> ($stable(flags_o) && $stable(wreg_o)));

    a_r6_mul_product: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dec_op == OP_MUL) |=>
        (prod_o == PROD_W'($past(wreg_o)) * PROD_W'($past(instr_word[7:0]))));

    a_r11_unsup_no_state: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported_o |-> ($stable(wreg_o) && $stable(flags_o) && $stable(ptr_o)
                           && $stable(bank_o) && $stable(prod_o)));

    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(wreg_o) && $stable(flags_o) && $stable(ptr_o)
                          && $stable(bank_o) && $stable(prod_o) && !unsupported_o));

    a_r7_bank_source: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dec_op != OP_BANK) |=> $stable(bank_o));

    a_r9_lone_second_word: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dec_op == OP_PTR_LO && !st_q.pend) |=> ($stable(ptr_o) && !unsupported_o));

    a_r5_mov_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dec_op == OP_MOV) |=> $stable(flags_o));
endmodule

// File: tb/sim_lit_exec_unit.sv
module sim_lit_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = 16'h0;
    logic [7:0]  wreg_o;
    logic [3:0]  bank_o;
    logic [35:0] ptr_o;
    logic [15:0] prod_o;
    logic [4:0]  flags_o;
    logic        unsupported_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lit_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .wreg_o(wreg_o), .bank_o(bank_o), .ptr_o(ptr_o), .prod_o(prod_o),
        .flags_o(flags_o), .unsupported_o(unsupported_o)
    );

    typedef struct packed {
        logic [15:0] ins;
        logic [7:0]  w;
        logic [4:0]  f;
        logic [15:0] p;
        logic [3:0]  b;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{16'h0E3C, 8'h3C, 5'b00000, 16'h0000, 4'h0, 4'd5},  // R5 load
        '{16'h0FC4, 8'h00, 5'b00111, 16'h0000, 4'h0, 4'd2},  // R2 carry to zero
        '{16'h0E7F, 8'h7F, 5'b00111, 16'h0000, 4'h0, 4'd5},  // R5 flags kept
        '{16'h0F01, 8'h80, 5'b11010, 16'h0000, 4'h0, 4'd2},  // R2 signed overflow
        '{16'h0E05, 8'h05, 5'b11010, 16'h0000, 4'h0, 4'd5},
        '{16'h0803, 8'hFE, 5'b10000, 16'h0000, 4'h0, 4'd3},  // R3 borrow
        '{16'h0E05, 8'h05, 5'b10000, 16'h0000, 4'h0, 4'd5},
        '{16'h0805, 8'h00, 5'b00111, 16'h0000, 4'h0, 4'd3},  // R3 equal, no borrow
        '{16'h0EF0, 8'hF0, 5'b00111, 16'h0000, 4'h0, 4'd5},
        '{16'h0B0F, 8'h00, 5'b00111, 16'h0000, 4'h0, 4'd4},  // R4 and
        '{16'h0981, 8'h81, 5'b10011, 16'h0000, 4'h0, 4'd4},  // R4 or
        '{16'h0A81, 8'h00, 5'b00111, 16'h0000, 4'h0, 4'd4},  // R4 xor
        '{16'h0AA5, 8'hA5, 5'b10011, 16'h0000, 4'h0, 4'd4},
        '{16'h0880, 8'hDB, 5'b10000, 16'h0000, 4'h0, 4'd3},  // R3 neg minus neg
        '{16'h087F, 8'hA4, 5'b11010, 16'h0000, 4'h0, 4'd3},  // R3 pos minus neg overflow
        '{16'h0D10, 8'hA4, 5'b11010, 16'h0A40, 4'h0, 4'd6},  // R6
        '{16'h0DFF, 8'hA4, 5'b11010, 16'hA35C, 4'h0, 4'd6},  // R6 max literal
        '{16'h0109, 8'hA4, 5'b11010, 16'hA35C, 4'h9, 4'd7}   // R7
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic exec(input logic [15:0] w);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  w_save;
        logic [4:0]  f_save;
        logic [35:0] p_save;
        idle(3);
        check("R1 wreg",  64'(wreg_o), 0);
        check("R1 bank",  64'(bank_o), 0);
        check("R1 ptr",   64'(ptr_o), 0);
        check("R1 prod",  64'(prod_o), 0);
        check("R1 flags", 64'(flags_o), 0);
        check("R1 unsup", 64'(unsupported_o), 0);
        rst_n = 1'b1;
        idle(1);

        for (int i = 0; i < NV; i++) begin
            exec(VT[i].ins);
            check($sformatf("R%0d vec%0d wreg", VT[i].rq, i), 64'(wreg_o), 64'(VT[i].w));
            check($sformatf("R%0d vec%0d flags", VT[i].rq, i), 64'(flags_o), 64'(VT[i].f));
            check($sformatf("R%0d vec%0d prod", VT[i].rq, i), 64'(prod_o), 64'(VT[i].p));
            check($sformatf("R%0d vec%0d bank", VT[i].rq, i), 64'(bank_o), 64'(VT[i].b));
        end

        // R8: load pointer 1 with 0xABC back to back
        exec(16'hEE1A);
        exec(16'hF0BC);
        check("R8 ptr1", 64'(ptr_o), 64'({12'h000, 12'hABC, 12'h000}));
        check("R8 wreg kept", 64'(wreg_o), 64'h A4);
        // R8: pointer 2 with idle gap
        exec(16'hEE21);
        idle(3);
        exec(16'hF023);
        check("R8 ptr2 gap", 64'(ptr_o), 64'({12'h123, 12'hABC, 12'h000}));

        // R9: lone second word
        w_save = wreg_o; f_save = flags_o; p_save = ptr_o;
        exec(16'hF055);
        check("R9 ptr", 64'(ptr_o), 64'(p_save));
        check("R9 wreg", 64'(wreg_o), 64'(w_save));
        check("R9 unsup", 64'(unsupported_o), 0);

        // R10: interrupted first word
        exec(16'hEE05);
        exec(16'h0E11);
        check("R10 middle executes", 64'(wreg_o), 64'h11);
        exec(16'hF077);
        check("R10 ptr0 untouched", 64'(ptr_o), 64'({12'h123, 12'hABC, 12'h000}));

        // R11: unsupported encodings
        f_save = flags_o;
        exec(16'h0C55);
        check("R11 unsup pulse", 64'(unsupported_o), 1);
        check("R11 wreg", 64'(wreg_o), 64'h11);
        check("R11 flags", 64'(flags_o), 64'(f_save));
        idle(1);
        check("R11 pulse ends", 64'(unsupported_o), 0);
        exec(16'hEE3A);
        check("R11 ptr idx3 unsup", 64'(unsupported_o), 1);
        exec(16'hF0FF);
        check("R11 ptr idx3 no load", 64'(ptr_o), 64'({12'h123, 12'hABC, 12'h000}));

        // R12: valid low with a live word on the bus
        @(negedge clk);
        instr_word = 16'h0E99;
        idle(3);
        check("R12 wreg", 64'(wreg_o), 64'h11);
        check("R12 unsup", 64'(unsupported_o), 0);

        // R1: reset again clears everything
        rst_n = 1'b0;
        idle(1);
        check("R1 rereset ptr", 64'(ptr_o), 0);
        check("R1 rereset wreg", 64'(wreg_o), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule